// File: doc/BRIEF.md
# 8-bit ALU with Masked Status Flags

This block is the arithmetic and logic stage of a small register-to-register processor. Each cycle it takes a destination operand, a second operand and a 5-bit operation code. The second operand is either a register value or an immediate; the caller chooses between them before the port. The stage returns a result byte and a write-enable for that result. It also returns five candidate flag values (carry, zero, negative, overflow, half-carry) and a mask that selects which of them the operation is allowed to change.

A registered flag holder is built into the block. When `exec_en` is high at a rising clock edge, every flag whose mask bit is set takes its new value, and every other flag keeps its old one. The held carry feeds the carry- and borrow-using operations. The held zero flag feeds the chained zero rule of the borrow-using subtract and compare, so that a compare across several bytes gives a correct zero result.

The result output always shows the computed value, including for operations that do not write it back. The register file, instruction decode and memory lie outside the block.

Top module: `alu8_core`

## Requirements
- R1: ADD (code 0) returns opa+opb and ADC (code 1) returns opa+opb+C. Both write the result. Both update all five flags: C is the carry out of bit 7, H is the carry out of bit 3, and V is the signed overflow. The flag bits are laid out as in R10.
- R2: SUB (code 2) returns opa-opb and SBC (code 3) returns opa-opb-C. Both write the result. Both update all five flags, with C being the borrow out of bit 7 and H the borrow out of bit 3.
- R3: CMP (code 4) and CPC (code 5) perform the SUB and SBC subtractions respectively. They update all five flags and hold `res_we` low.
- R4: For SBC and CPC, the new Z is 1 only when the result is zero and the held Z is already 1.
- R5: AND (6), OR (7), XOR (8), clear-bits (9, opa AND NOT opb) and set-bits (10, opa OR opb) write the result. They update only Z, N and V, with V forced to 0.
- R6: INC (16) and DEC (17) write opa+1 and opa-1. They update only Z, N and V. V is 1 exactly when INC sees 7Fh or DEC sees 80h.
- R7: COM (14) writes FFh-opa. It updates C, Z, N and V, with C forced to 1 and V forced to 0. H is unchanged.
- R8: NEG (15) writes 00h-opa and updates all five flags as that subtraction.
- R9: TST (11) computes opa AND opa and updates Z, N and V without writing. CLR (12) writes 00h and updates Z, N and V. SER (13) writes FFh and changes no flag.
- R10: The flag holder uses bit 0 for C, 1 for Z, 2 for N, 3 for V and 4 for H. It resets to all zero. On a clock edge with `exec_en` high, it loads exactly the masked bits. With `exec_en` low, it holds.
- R11: Codes 18 to 31 neither write a result nor update any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flag holder |
| exec_en | input | 1 | Commit the masked flag update at this edge |
| op_sel | input | 5 | Operation code |
| opa | input | 8 | Destination operand |
| opb | input | 8 | Source register or immediate |
| res | output | 8 | Computed result |
| res_we | output | 1 | Result is to be written back |
| flag_mask | output | 5 | Flags this operation updates |
| flag_new | output | 5 | Candidate flag values |
| flags_q | output | 5 | Held flags |

## Verification
The bench drives operands drawn heavily from 00h, 01h, 0Fh, 10h, 7Fh, 80h and FFh. These values sit on the nibble carry, signed overflow and wrap-around boundaries, and a wrong half-carry or overflow equation shows up there first, as a flipped H or V. Random `exec_en` gaps and random opcodes before a borrow-using operation test carry and zero chaining. A design that ignored the held Z would report equal for a multi-byte compare whose low byte differed. A mask leak would show as C or H changing after a logic, increment or COM operation. The bench also confirms that compares never raise `res_we` and that undefined codes leave the held flags untouched.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, flag bit positions, opcodes and logic selects for alu8_core.
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int NFLAG  = 5;
    localparam int OP_W   = 5;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_H = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_CMP = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
        OP_XOR = 5'd8,  OP_CBR = 5'd9,  OP_SBR = 5'd10, OP_TST = 5'd11,
        OP_CLR = 5'd12, OP_SER = 5'd13, OP_COM = 5'd14, OP_NEG = 5'd15,
        OP_INC = 5'd16, OP_DEC = 5'd17
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND  = 2'd0,
        LG_OR   = 2'd1,
        LG_XOR  = 2'd2,
        LG_ANDN = 2'd3
    } logic_sel_e;
endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
// Module: alu8_addsub
// Adder/subtractor built from two chained segments. Sub mode adds the
// complement of y. cin is a carry when adding and a borrow when subtracting;
// c_out and h_out follow the same convention. Assumes W > 4.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    localparam int LW = 4;
    localparam int HW = W - LW;

    logic [W-1:0] ym;
    logic         ci;
    logic [LW:0]  lo_s;
    logic [HW:0]  hi_s;

    // Form the effective addend and carry, then sum the two segments.
    always_comb begin
        ym    = sub ? ~y : y;
        ci    = sub ? ~cin : cin;
        lo_s  = {1'b0, x[LW-1:0]} + {1'b0, ym[LW-1:0]} + {{LW{1'b0}}, ci};
        hi_s  = {1'b0, x[W-1:LW]} + {1'b0, ym[W-1:LW]} + {{HW{1'b0}}, lo_s[LW]};
        r     = {hi_s[HW-1:0], lo_s[LW-1:0]};
        c_out = sub ? ~hi_s[HW] : hi_s[HW];
        h_out = sub ? ~lo_s[LW] : lo_s[LW];
        v_out = (x[W-1] == ym[W-1]) && (r[W-1] != x[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
// Module: alu8_logic
// Bitwise unit: AND, OR, XOR or AND-with-complement, picked by sel.
// Purely combinational; no flags are produced here.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] y
);
    // Select the bitwise function.
    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = a & ~b;
        endcase
    end
endmodule

// File: rtl/alu8_flag_reg.sv
`timescale 1ns/1ps
// Module: alu8_flag_reg
// Status holder: on upd, each bit with its mask set loads din; other bits keep
// their value. Synchronous active-low reset clears all bits.
module alu8_flag_reg #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] din,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit masked load.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (upd && mask[i])
                q[i] <= din[i];
        end
    end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
// Module: alu8_core (top)
// Decodes the opcode into controls for the adder and the logic unit, forms
// the result, write-enable, candidate flags and update mask, and holds the
// flags. Held C feeds carry/borrow ops; held Z feeds the chained zero rule.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NF = NFLAG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_en,
    input  logic [OP_W-1:0] op_sel,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res,
    output logic          res_we,
    output logic [NF-1:0] flag_mask,
    output logic [NF-1:0] flag_new,
    output logic [NF-1:0] flags_q
);
    localparam logic [NF-1:0] M_ALL = '1;
    localparam logic [NF-1:0] M_ZNV = NF'((1 << FLG_Z) | (1 << FLG_N) | (1 << FLG_V));
    localparam logic [NF-1:0] M_CZNV = M_ZNV | NF'(1 << FLG_C);

    alu_op_e      op;
    logic [DW-1:0] as_x, as_y, as_r, lg_b, lg_y;
    logic         as_sub, as_cin, as_c, as_h, as_v;
    logic_sel_e   lg_sel;
    logic         use_arith, zchain;

    assign op = alu_op_e'(op_sel);

    // Opcode decode into datapath controls, write-enable and flag mask.
    always_comb begin
        as_x = opa;  as_y = opb;  as_sub = 1'b0;  as_cin = 1'b0;
        lg_b = opb;  lg_sel = LG_AND;  use_arith = 1'b1;  zchain = 1'b0;
        res_we = 1'b1;  flag_mask = '0;
        case (op)
            OP_ADD: flag_mask = M_ALL;
            OP_ADC: begin as_cin = flags_q[FLG_C]; flag_mask = M_ALL; end
            OP_SUB: begin as_sub = 1'b1; flag_mask = M_ALL; end
            OP_SBC: begin as_sub = 1'b1; as_cin = flags_q[FLG_C]; zchain = 1'b1; flag_mask = M_ALL; end
            OP_CMP: begin as_sub = 1'b1; res_we = 1'b0; flag_mask = M_ALL; end
            OP_CPC: begin as_sub = 1'b1; as_cin = flags_q[FLG_C]; zchain = 1'b1; res_we = 1'b0; flag_mask = M_ALL; end
            OP_AND: begin use_arith = 1'b0; lg_sel = LG_AND; flag_mask = M_ZNV; end
            OP_OR:  begin use_arith = 1'b0; lg_sel = LG_OR; flag_mask = M_ZNV; end
            OP_XOR: begin use_arith = 1'b0; lg_sel = LG_XOR; flag_mask = M_ZNV; end
            OP_CBR: begin use_arith = 1'b0; lg_sel = LG_ANDN; flag_mask = M_ZNV; end
            OP_SBR: begin use_arith = 1'b0; lg_sel = LG_OR; flag_mask = M_ZNV; end
            OP_TST: begin use_arith = 1'b0; lg_sel = LG_AND; lg_b = opa; res_we = 1'b0; flag_mask = M_ZNV; end
            OP_CLR: begin use_arith = 1'b0; lg_sel = LG_XOR; lg_b = opa; flag_mask = M_ZNV; end
            OP_SER: begin use_arith = 1'b0; lg_sel = LG_OR; lg_b = '1; end
            OP_COM: begin use_arith = 1'b0; lg_sel = LG_XOR; lg_b = '1; flag_mask = M_CZNV; end
            OP_NEG: begin as_x = '0; as_y = opa; as_sub = 1'b1; flag_mask = M_ALL; end
            OP_INC: begin as_y = DW'(1); flag_mask = M_ZNV; end
            OP_DEC: begin as_y = DW'(1); as_sub = 1'b1; flag_mask = M_ZNV; end
            default: res_we = 1'b0;
        endcase
    end

    alu8_addsub #(.W(DW)) u_addsub (
        .x(as_x), .y(as_y), .sub(as_sub), .cin(as_cin),
        .r(as_r), .c_out(as_c), .h_out(as_h), .v_out(as_v)
    );

    alu8_logic #(.W(DW)) u_logic (
        .a(opa), .b(lg_b), .sel(lg_sel), .y(lg_y)
    );

    // Result select and candidate flag formation.
    always_comb begin
        res = use_arith ? as_r : lg_y;
        flag_new = '0;
        flag_new[FLG_C] = use_arith ? as_c : 1'b1;
        flag_new[FLG_H] = as_h;
        flag_new[FLG_V] = use_arith ? as_v : 1'b0;
        flag_new[FLG_N] = res[DW-1];
        flag_new[FLG_Z] = (res == '0) && (!zchain || flags_q[FLG_Z]);
    end

    alu8_flag_reg #(.N(NF)) u_flags (
        .clk(clk), .rst_n(rst_n), .upd(exec_en),
        .mask(flag_mask), .din(flag_new), .q(flags_q)
    );
endmodule

// File: rtl/alu8_core_chk.sv
`timescale 1ns/1ps
// Module: alu8_core_chk
// Property checker bound to alu8_core; observes ports only.
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        exec_en,
    input logic [4:0]  op_sel,
    input logic [7:0]  res,
    input logic        res_we,
    input logic [4:0]  flag_mask,
    input logic [4:0]  flag_new,
    input logic [4:0]  flags_q
);
    logic is_cmp, is_chain, is_logic;
    assign is_cmp   = (op_sel == OP_CMP) || (op_sel == OP_CPC);
    assign is_chain = (op_sel == OP_SBC) || (op_sel == OP_CPC);
    assign is_logic = (op_sel >= OP_AND) && (op_sel <= OP_SBR);

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(flags_q)); // R10
    AST_KEEP_UNMASKED_C: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && !flag_mask[FLG_C] |=> flags_q[FLG_C] == $past(flags_q[FLG_C])); // R10
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |-> !res_we); // R3
    AST_CHAIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_chain && flag_new[FLG_Z] |-> (res == 8'h00) && flags_q[FLG_Z]); // R4
    AST_LOGIC_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && is_logic |=> !flags_q[FLG_V]); // R5
    AST_COM_SETS_C: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && op_sel == OP_COM |=> flags_q[FLG_C]); // R7
    AST_SER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == OP_SER |-> flag_mask == 5'b0 && res == 8'hFF); // R9
    AST_UNDEF_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel > OP_DEC |-> flag_mask == 5'b0 && !res_we); // R11
endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
    .res(res), .res_we(res_we), .flag_mask(flag_mask),
    .flag_new(flag_new), .flags_q(flags_q)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every cycle against alu8_core.
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       exec_en;
    logic [4:0] op_sel;
    logic [7:0] opa, opb, res;
    logic       res_we;
    logic [4:0] flag_mask, flag_new, flags_q;

    int  nchk = 0;
    int  nerr = 0;
    bit  done = 0;
    int  mq   = 0;

    always #2 clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
        .opa(opa), .opb(opb), .res(res), .res_we(res_we),
        .flag_mask(flag_mask), .flag_new(flag_new), .flags_q(flags_q)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int sx(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0, 1:             return "R1";
            2:                return "R2";
            3:                return "R2/R4";
            4:                return "R3";
            5:                return "R3/R4";
            6, 7, 8, 9, 10:   return "R5";
            11, 12, 13:       return "R9";
            14:               return "R7";
            15:               return "R8";
            16, 17:           return "R6";
            default:          return "R11";
        endcase
    endfunction

    // Reference: result, write-enable, mask and new flags from the requirements.
    function automatic void model(input int op, input int a, input int b, input int fq,
                                  output int r, output int we, output int mask, output int nf);
        int c, z, n, v, h, s, cin, chain;
        c = 0; v = 0; h = 0; chain = 0; we = 1; mask = 0; r = 0;
        cin = fq & 1;
        case (op)
            0, 1: begin
                if (op == 0) cin = 0;
                s = a + b + cin; r = s & 255; c = (s > 255);
                h = ((a & 15) + (b & 15) + cin) > 15;
                s = sx(a) + sx(b) + cin; v = (s > 127 || s < -128); mask = 31;
            end
            2, 3, 4, 5, 15: begin
                int x, y;
                x = (op == 15) ? 0 : a;  y = (op == 15) ? a : b;
                if (op != 3 && op != 5) cin = 0;
                chain = (op == 3 || op == 5);
                s = x - y - cin; r = s & 255; c = (s < 0);
                h = ((x & 15) - (y & 15) - cin) < 0;
                s = sx(x) - sx(y) - cin; v = (s > 127 || s < -128);
                mask = 31; we = (op != 4 && op != 5);
            end
            6:  begin r = a & b; mask = 14; end
            7:  begin r = a | b; mask = 14; end
            8:  begin r = a ^ b; mask = 14; end
            9:  begin r = a & (255 - b); mask = 14; end
            10: begin r = a | b; mask = 14; end
            11: begin r = a; mask = 14; we = 0; end
            12: begin r = 0; mask = 14; end
            13: begin r = 255; mask = 0; end
            14: begin r = 255 - a; c = 1; mask = 15; end
            16: begin r = (a + 1) & 255; v = (a == 127); mask = 14; end
            17: begin r = (a + 255) & 255; v = (a == 128); mask = 14; end
            default: begin we = 0; mask = 0; end
        endcase
        z = (r == 0) && (!chain || ((fq >> 1) & 1));
        n = (r >> 7) & 1;
        nf = c | (z << 1) | (n << 2) | (v << 3) | (h << 4);
    endfunction

    function automatic int pick();
        case ($urandom % 8)
            0: return 8'h00;
            1: return 8'h7F;
            2: return 8'h80;
            3: return 8'hFF;
            4: return 8'h01;
            5: return 8'h0F;
            6: return 8'h10;
            default: return int'($urandom % 256);
        endcase
    endfunction

    task automatic step(input int op, input int a, input int b, input bit en);
        int r, we, mask, nf, nxt;
        string t;
        @(negedge clk);
        op_sel = 5'(op); opa = 8'(a); opb = 8'(b); exec_en = en;
        #1;
        model(op, a, b, mq, r, we, mask, nf);
        t = req_of(op);
        if (op <= 17) chk(t, "res", int'(res), r);
        chk(t, "res_we", int'(res_we), we);
        chk(t, "flag_mask", int'(flag_mask), mask);
        chk(t, "flag_new&mask", int'(flag_new) & mask, nf & mask);
        nxt = en ? ((mq & ~mask) | (nf & mask)) & 31 : mq;
        @(posedge clk);
        #1;
        mq = nxt;
        chk("R10", "flags_q", int'(flags_q), mq);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            nerr++;
            $display("FAIL R10 watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; exec_en = 1'b1; op_sel = 5'd0; opa = 8'hFF; opb = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "reset flags_q", int'(flags_q), 0);
        rst_n = 1'b1;
        // Directed boundary cases.
        step(0, 8'h7F, 8'h01, 1);   // R1 overflow and half-carry
        step(0, 8'hFF, 8'h01, 1);   // R1 carry out, zero
        step(1, 8'h00, 8'h00, 1);   // R1 ADC with C=1
        step(2, 8'h80, 8'h01, 1);   // R2 signed overflow
        step(5, 8'h00, 8'h00, 1);   // R4 chain with Z held
        step(14, 8'h00, 8'h00, 1);  // R7 COM
        step(15, 8'h80, 8'h00, 1);  // R8 NEG of 80h
        step(16, 8'h7F, 8'h00, 1);  // R6 INC overflow
        step(17, 8'h80, 8'h00, 1);  // R6 DEC overflow
        step(13, 8'h12, 8'h34, 1);  // R9 SER
        step(20, 8'h00, 8'h00, 1);  // R11 undefined code
        step(4, 8'h05, 8'h05, 0);   // R10 hold without exec_en
        for (int i = 0; i < 4000; i++)
            step(int'($urandom_range(0, 19)), pick(), pick(), ($urandom % 4) != 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule